// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

This block raises a base C to an exponent e modulo an odd modulus N of K bits, with R = 2^K. No step uses trial division. Every modular multiplication goes through a single bit-serial Montgomery product unit, which returns A·B·R^-1 mod N. Each product takes one operand bit per cycle and ends with one conditional subtraction. A sequencer moves the base into the Montgomery domain by multiplying it with R^2 mod N. It then walks the exponent from its highest set bit downwards: it squares for every bit and also multiplies for every set bit. At the end it leaves the domain by multiplying with 1.

The caller supplies C (which must be below N), e, N and the constant R^2 mod N, and then pulses a start strobe. When the answer is ready a one-cycle completion pulse appears, and the result stays on the output until the next computation finishes. A start strobe that arrives while a computation is running has no effect.

Top module: `modexp_engine`

## Requirements
- R1: For odd N, C < N and `r2_i` = 2^(2K) mod N, the value on `result_o` in the completion cycle equals C^e mod N.
- R2: `done_o` is high for exactly one cycle per accepted start, and `result_o` is valid in that cycle.
- R3: Every Montgomery product, and therefore `result_o`, is strictly less than N (0 when N = 1).
- R4: An exponent of 0 returns 1 mod N (1 for N > 1, 0 for N = 1).
- R5: A base of 0 with an exponent of at least 1 returns 0.
- R6: A start pulse seen while a computation is running is ignored: that run's result and its single completion pulse are unchanged, and no further pulse follows.
- R7: `result_o` does not change except in a cycle where `done_o` is high.
- R8: A start pulse presented in the same cycle as `done_o` is accepted and begins a new computation.
- R9: Each Montgomery product takes K+3 cycles from launch to the next launch. Relative to e = 1, each further square or multiply adds exactly K+3 cycles: e = 3 and e = 4 both take two more products than e = 1, and e = 0 takes one more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled only while idle |
| base_i | input | K | Base C, must be below N |
| exp_i | input | K | Exponent e |
| mod_i | input | K | Odd modulus N |
| r2_i | input | K | Precomputed 2^(2K) mod N |
| result_o | output | K | C^e mod N, held until the next completion |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can coincide in one cycle. The completion pulse of one run and the acceptance of the next start can fall together. A running computation and a start pulse meant to be ignored can also fall together. The bench raises start exactly in the cycle where it observes `done_o`. It then checks that the second operand set produces its own correct result. A second test sends a start with different operands partway through a long exponent. It checks that the first run's result is returned, with exactly one completion pulse in a window long enough for the second run to have finished.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ENTRY,
    PH_ONE,
    PH_SQR,
    PH_MUL,
    PH_EXIT
  } phase_t;

  typedef enum logic [1:0] {
    MM_IDLE,
    MM_RUN,
    MM_FIN
  } mm_state_t;

endpackage

// File: rtl/mont_mul.sv
module mont_mul
  import mexp_pkg::*;
#(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  input  logic [K-1:0] n_i,
  output logic         done_o,
  output logic [K-1:0] res_o
);

  localparam int CW = (K > 1) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST = CW'(K - 1);

  // One radix-2 step: add a_bit*B, add N if the sum is odd, halve.
  function automatic logic [K:0] step_fn(logic [K:0] p, logic abit,
                                         logic [K-1:0] b, logic [K-1:0] n);
    logic [K+1:0] s;
    logic         q;
    q = p[0] ^ (abit & b[0]);
    s = {1'b0, p} + (abit ? {2'b00, b} : '0) + (q ? {2'b00, n} : '0);
    return s[K+1:1];
  endfunction

  // Final correction: the partial product is below 2N, one subtract suffices.
  function automatic logic [K-1:0] reduce_fn(logic [K:0] p, logic [K-1:0] n);
    logic [K:0] d;
    d = p - {1'b0, n};
    if (p >= {1'b0, n}) return d[K-1:0];
    else                return p[K-1:0];
  endfunction

  mm_state_t     st_q;
  logic [CW-1:0] cnt_q;
  logic [K-1:0]  a_q, b_q, n_q, res_q;
  logic [K:0]    p_q;
  logic          done_q;

  logic last_w;
  logic fin_w;
  assign last_w = (st_q == MM_RUN) && (cnt_q == LAST);
  assign fin_w  = (st_q == MM_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MM_IDLE;
      cnt_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      n_q    <= '0;
      p_q    <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        MM_IDLE: if (go_i) begin
          a_q   <= a_i;
          b_q   <= b_i;
          n_q   <= n_i;
          p_q   <= '0;
          cnt_q <= '0;
          st_q  <= MM_RUN;
        end
        MM_RUN: begin
          p_q   <= step_fn(p_q, a_q[0], b_q, n_q);
          a_q   <= a_q >> 1;
          cnt_q <= cnt_q + 1'b1;
          if (last_w) st_q <= MM_FIN;
        end
        MM_FIN: begin
          res_q  <= reduce_fn(p_q, n_q);
          done_q <= 1'b1;
          st_q   <= MM_IDLE;
        end
        default: st_q <= MM_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;

  a_r3_product_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (res_o < n_q) || (n_q == K'(1) && res_o == '0));

  a_r6_no_launch_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> st_q == MM_IDLE);

  a_r9_fin_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> fin_w);

  a_r2_unit_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/exp_seq.sv
module exp_seq
  import mexp_pkg::*;
#(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [K-1:0] base_i,
  input  logic [K-1:0] exp_i,
  input  logic [K-1:0] mod_i,
  input  logic [K-1:0] r2_i,
  output logic         mm_go_o,
  output logic [K-1:0] mm_a_o,
  output logic [K-1:0] mm_b_o,
  output logic [K-1:0] mm_n_o,
  input  logic         mm_done_i,
  input  logic [K-1:0] mm_res_i,
  output logic [K-1:0] result_o,
  output logic         done_o
);

  localparam int BW = (K > 1) ? $clog2(K) : 1;
  localparam logic [K-1:0] ONE = K'(1);

  function automatic logic [BW-1:0] top_bit(logic [K-1:0] e);
    logic [BW-1:0] t;
    t = '0;
    for (int i = 0; i < K; i++) if (e[i]) t = BW'(i);
    return t;
  endfunction

  phase_t        ph_q;
  logic [K-1:0]  e_q, n_q, r2_q, xb_q, opa_q, opb_q, res_q;
  logic [BW-1:0] bit_q;
  logic          go_q, done_q;

  logic accept_w;
  logic bit_last_w;
  assign accept_w   = (ph_q == PH_IDLE) && start_i;
  assign bit_last_w = (bit_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      e_q    <= '0;
      n_q    <= '0;
      r2_q   <= '0;
      xb_q   <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      res_q  <= '0;
      bit_q  <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (accept_w) begin
          e_q   <= exp_i;
          n_q   <= mod_i;
          r2_q  <= r2_i;
          opa_q <= base_i;
          opb_q <= r2_i;
          go_q  <= 1'b1;
          ph_q  <= PH_ENTRY;
        end
        PH_ENTRY: if (mm_done_i) begin
          xb_q <= mm_res_i;
          go_q <= 1'b1;
          if (e_q == '0) begin
            opa_q <= r2_q;
            opb_q <= ONE;
            ph_q  <= PH_ONE;
          end else if (top_bit(e_q) == '0) begin
            opa_q <= mm_res_i;
            opb_q <= ONE;
            ph_q  <= PH_EXIT;
          end else begin
            bit_q <= top_bit(e_q) - 1'b1;
            opa_q <= mm_res_i;
            opb_q <= mm_res_i;
            ph_q  <= PH_SQR;
          end
        end
        PH_ONE: if (mm_done_i) begin
          opa_q <= mm_res_i;
          opb_q <= ONE;
          go_q  <= 1'b1;
          ph_q  <= PH_EXIT;
        end
        PH_SQR, PH_MUL: if (mm_done_i) begin
          go_q <= 1'b1;
          if (ph_q == PH_SQR && e_q[bit_q]) begin
            opa_q <= mm_res_i;
            opb_q <= xb_q;
            ph_q  <= PH_MUL;
          end else if (bit_last_w) begin
            opa_q <= mm_res_i;
            opb_q <= ONE;
            ph_q  <= PH_EXIT;
          end else begin
            bit_q <= bit_q - 1'b1;
            opa_q <= mm_res_i;
            opb_q <= mm_res_i;
            ph_q  <= PH_SQR;
          end
        end
        PH_EXIT: if (mm_done_i) begin
          res_q  <= mm_res_i;
          done_q <= 1'b1;
          ph_q   <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign mm_go_o  = go_q;
  assign mm_a_o   = opa_q;
  assign mm_b_o   = opb_q;
  assign mm_n_o   = n_q;
  assign result_o = res_q;
  assign done_o   = done_q;

  a_r6_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && start_i) |=> $stable(e_q) && $stable(n_q) && $stable(r2_q));

  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  a_r1_done_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ph_q) == PH_EXIT);

  a_r9_launch_single: assert property (@(posedge clk) disable iff (!rst_n)
    mm_go_o |=> !mm_go_o);

  a_r8_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ph_q == PH_IDLE);

endmodule

// File: rtl/modexp_engine.sv
module modexp_engine #(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [K-1:0] base_i,
  input  logic [K-1:0] exp_i,
  input  logic [K-1:0] mod_i,
  input  logic [K-1:0] r2_i,
  output logic [K-1:0] result_o,
  output logic         done_o
);

  logic         mm_go_w;
  logic [K-1:0] mm_a_w, mm_b_w, mm_n_w, mm_res_w;
  logic         mm_done_w;

  exp_seq #(.K(K)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .base_i    (base_i),
    .exp_i     (exp_i),
    .mod_i     (mod_i),
    .r2_i      (r2_i),
    .mm_go_o   (mm_go_w),
    .mm_a_o    (mm_a_w),
    .mm_b_o    (mm_b_w),
    .mm_n_o    (mm_n_w),
    .mm_done_i (mm_done_w),
    .mm_res_i  (mm_res_w),
    .result_o  (result_o),
    .done_o    (done_o)
  );

  mont_mul #(.K(K)) mul_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (mm_go_w),
    .a_i    (mm_a_w),
    .b_i    (mm_b_w),
    .n_i    (mm_n_w),
    .done_o (mm_done_w),
    .res_o  (mm_res_w)
  );

endmodule

// File: tb/modexp_engine_tb_top.sv
module modexp_engine_tb_top;

  localparam int K = 8;
  localparam int PROD = K + 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [K-1:0] base_i = '0, exp_i = '0, mod_i = '0, r2_i = '0;
  logic [K-1:0] result_o;
  logic         done_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  modexp_engine #(.K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .base_i(base_i), .exp_i(exp_i), .mod_i(mod_i), .r2_i(r2_i),
    .result_o(result_o), .done_o(done_o)
  );

  function automatic longint ref_pow(longint c, longint e, longint n);
    longint r, b, x;
    r = 1; b = c % n; x = e;
    while (x != 0) begin
      if (x[0]) r = (r * b) % n;
      b = (b * b) % n;
      x = x >> 1;
    end
    return r % n;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(longint c, longint e, longint n);
    base_i  = K'(c);
    exp_i   = K'(e);
    mod_i   = K'(n);
    r2_i    = K'((longint'(1) << (2 * K)) % n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done_o && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
    if (!done_o) begin
      failures++;
      $display("FAIL R2 completion missing actual=timeout expected=done");
    end
  endtask

  task automatic run_one(longint c, longint e, longint n, output int lat);
    string tag;
    longint expv;
    launch(c, e, n);
    wait_done(lat);
    expv = ref_pow(c, e, n);
    tag = (e == 0) ? "R4 zero exponent" : (c == 0) ? "R5 zero base" : "R1 power";
    check(tag, result_o, expv);
    check("R3 below modulus", (result_o < n || (n == 1 && result_o == 0)) ? 1 : 0, 1);
    @(negedge clk);
    check("R2 done width", done_o, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    failures++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat, l0, l1, l2, l3, l4, pulses;
    longint hold_v;
    repeat (3) @(negedge clk);
    check("R7 reset result", result_o, 0);
    check("R2 reset done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep of moduli, bases and exponents (R1, R3, R4, R5)
    for (int n = 1; n < 256; n += 22) begin
      longint cl[4];
      longint el[8];
      cl = '{0, 1, n / 3, n - 1};
      el = '{0, 1, 2, 3, 5, 128, 170, 255};
      foreach (cl[ci]) foreach (el[ei])
        run_one(cl[ci] % n, el[ei], n, lat);
    end

    // R7: result held across idle cycles
    run_one(9, 77, 251, lat);
    hold_v = result_o;
    repeat (20) @(negedge clk);
    check("R7 result held", result_o, hold_v);

    // R9: latency relations
    run_one(7, 0, 101, l0);
    run_one(7, 1, 101, l1);
    run_one(7, 2, 101, l2);
    run_one(7, 3, 101, l3);
    run_one(7, 4, 101, l4);
    check("R9 e=0 vs e=1", l0 - l1, PROD);
    check("R9 e=2 vs e=1", l2 - l1, PROD);
    check("R9 e=3 vs e=1", l3 - l1, 2 * PROD);
    check("R9 e=4 vs e=1", l4 - l1, 2 * PROD);

    // R6: start while busy is ignored
    launch(13, 255, 239);
    repeat (30) @(negedge clk);
    base_i = 5; exp_i = 3; mod_i = 17; r2_i = K'((1 << (2 * K)) % 17);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    pulses = 0;
    hold_v = -1;
    for (int i = 0; i < 600; i++) begin
      if (done_o) begin
        pulses++;
        if (hold_v < 0) hold_v = result_o;
      end
      @(negedge clk);
    end
    check("R6 busy start result", hold_v, ref_pow(13, 255, 239));
    check("R6 single completion", pulses, 1);

    // R8: start in the completion cycle is accepted
    launch(21, 200, 227);
    wait_done(lat);
    check("R8 first result", result_o, ref_pow(21, 200, 227));
    launch(44, 37, 191);
    wait_done(lat);
    check("R8 back-to-back result", result_o, ref_pow(44, 37, 191));
    @(negedge clk);
    check("R2 done width after chain", done_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule